// File: doc/BRIEF.md
# Decimal Result Condition Tracker

This block follows a zoned-decimal add or subtract while the result is produced one digit per cycle, low-order digit first. It watches the numeric output of the arithmetic unit, the result sign and the carry out of the high-order digit. From these it builds the condition code that the operation leaves behind: equal (the result is zero), low (the result is minus), high (the result is plus) and a separate decimal overflow flag.

A result can come out as zero with a minus sign. Every zero must read as plus, so in that case the block asks for a recomplement pass. When the surrounding sequencer reports that this pass is finished, the block forces the condition to high and withdraws the request.

The controller pulses `start_i` once for each operation. It then presents the result digits with `step_i`, marking the lowest digit with `first_i` and the highest with `last_i`. One clock after the last digit, the block raises `done_o` for a single cycle, and the final condition is valid from that cycle onward.

Top module: `dec_cond_tracker`

## Requirements
- R1: A `start_i` pulse sets `cond_o` to equal and clears `ovfl_o` and `recomp_req_o` on the next clock. It also opens a new operation. `start_i` takes priority over every other input.
- R2: The sign of the result is latched only from the step that has `first_i` set. A `sign_neg_i` value presented on any later step of the same operation has no effect.
- R3: `cond_o` uses the encoding equal=2'b00, low=2'b01 and high=2'b10, and never shows 2'b11. If any digit of the operation is non-zero, the final condition is low when the latched sign is minus and high when it is plus.
- R4: If every digit is zero and the latched sign is plus, the final condition is equal and no recomplement request is raised.
- R5: If every digit is zero and the latched sign is minus, the final condition stays equal and `recomp_req_o` is raised in the same cycle as `done_o`.
- R6: `ovfl_o` is set at the end of an operation only when `comp_add_i` is 1 and `carry_hi_i` is 0 on the last step. In every other case it ends at 0.
- R7: `done_o` is a one-cycle pulse in the cycle that follows the step with `last_i` set. `cond_o`, `ovfl_o` and `recomp_req_o` are final in that same cycle.
- R8: A `recomp_done_i` pulse while `recomp_req_o` is high sets `cond_o` to high and clears `recomp_req_o` on the next clock. While no request is pending, `recomp_done_i` has no effect.
- R9: A `step_i` that arrives while no operation is open is ignored. `done_o`, `cond_o` and `ovfl_o` do not change.
- R10: After reset, `cond_o` is equal and `ovfl_o`, `recomp_req_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Opens a new operation and clears the condition |
| step_i | input | 1 | A result digit is valid this cycle |
| first_i | input | 1 | This step carries the low-order digit |
| last_i | input | 1 | This step carries the high-order digit |
| sign_neg_i | input | 1 | Result sign, 1 for minus |
| digit_i | input | DIGIT_W | Numeric part of the result digit from the arithmetic unit |
| carry_hi_i | input | 1 | Carry out of the high-order digit |
| comp_add_i | input | 1 | Operation is an add with the A operand complemented |
| recomp_done_i | input | 1 | The recomplement pass has finished |
| cond_o | output | 2 | Final condition: 00 equal, 01 low, 10 high |
| ovfl_o | output | 1 | Decimal overflow |
| recomp_req_o | output | 1 | Request for a recomplement pass (minus zero) |
| done_o | output | 1 | One-cycle pulse when the condition is final |

## Verification
The bench sweeps operation lengths of one to three digits. It covers every zero/non-zero digit pattern, both signs, both operation types and both carry values. On every step after the first it drives the opposite sign, so a design that latches the sign on the wrong step reports low and high the wrong way round. The all-zero patterns catch a design that lets the sign through on a zero result. Such a design would report low for a minus zero, or would miss or spuriously raise the recomplement request. A single non-zero digit in the middle or at the top of the result catches an equal flag that depends only on the final digit. Stray steps outside an operation, and recomplement-done pulses with no request pending, expose a design that does not ignore those inputs.

// File: rtl/dct_pkg.sv
// Shared types for the decimal result condition tracker.
// Assumes a two-bit condition code in which 2'b11 is never produced.
package dct_pkg;
    typedef enum logic [1:0] {
        COND_EQ = 2'b00,
        COND_LO = 2'b01,
        COND_HI = 2'b10
    } cond_e;
endpackage

// File: rtl/dct_digit_zero.sv
// Flags a non-zero numeric digit coming from the arithmetic unit.
// Assumes the zone bits are already stripped from the digit.
module dct_digit_zero #(
    parameter int DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] digit_i,
    output logic               nonzero_o
);
    logic [DIGIT_W:0] chain;

    // OR-chain over the digit bits, built one bit per stage
    assign chain[0] = 1'b0;
    for (genvar b = 0; b < DIGIT_W; b++) begin : g_or
        assign chain[b+1] = chain[b] | digit_i[b];
    end
    assign nonzero_o = chain[DIGIT_W];
endmodule

// File: rtl/dct_track.sv
// Per-operation state: whether an operation is open, whether all digits
// so far were zero, and the sign latched from the first result step.
// Assumes start_i outranks step_i and that steps arrive low-order first.
module dct_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    input  logic first_i,
    input  logic last_i,
    input  logic sign_neg_i,
    input  logic digit_nz_i,
    output logic last_ok_o,
    output logic eq_after_o,
    output logic neg_after_o
);
    logic active_q;
    logic eq_q;
    logic neg_q;
    logic step_ok;

    // A step counts only inside an open operation and when no start is present
    assign step_ok     = step_i & active_q & ~start_i;
    assign last_ok_o   = step_ok & last_i;
    assign eq_after_o  = eq_q & ~digit_nz_i;
    assign neg_after_o = (step_ok & first_i) ? sign_neg_i : neg_q;

    // Open/close the operation, accumulate zero state and latch the sign
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            eq_q     <= 1'b1;
            neg_q    <= 1'b0;
        end else if (start_i) begin
            active_q <= 1'b1;
            eq_q     <= 1'b1;
            neg_q    <= 1'b0;
        end else if (step_ok) begin
            eq_q <= eq_after_o;
            if (first_i) neg_q <= sign_neg_i;
            if (last_i) active_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dct_cond_reg.sv
// Registers the final condition, the overflow flag, the recomplement
// request and the done pulse.
// Assumes last_ok_o from the tracker already excludes cycles with start.
module dct_cond_reg
    import dct_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  last_ok_i,
    input  logic  eq_after_i,
    input  logic  neg_after_i,
    input  logic  comp_add_i,
    input  logic  carry_hi_i,
    input  logic  recomp_done_i,
    output cond_e cond_o,
    output logic  ovfl_o,
    output logic  req_o,
    output logic  done_o
);
    cond_e final_cond;

    // Pick the condition that the last step leaves behind
    always_comb begin
        if (eq_after_i)       final_cond = COND_EQ;
        else if (neg_after_i) final_cond = COND_LO;
        else                  final_cond = COND_HI;
    end

    // Update the condition on start, on the last step, and when recomplement finishes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_o <= COND_EQ;
            ovfl_o <= 1'b0;
            req_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= last_ok_i;
            if (start_i) begin
                cond_o <= COND_EQ;
                ovfl_o <= 1'b0;
                req_o  <= 1'b0;
            end else if (last_ok_i) begin
                cond_o <= final_cond;
                req_o  <= eq_after_i & neg_after_i;
                ovfl_o <= comp_add_i & ~carry_hi_i;
            end else if (recomp_done_i && req_o) begin
                cond_o <= COND_HI;
                req_o  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dec_cond_tracker.sv
// Top level: builds the condition code of a digit-serial decimal
// add/subtract and requests a recomplement pass on a minus-zero result.
// Assumes the controller pulses start_i once per operation.
module dec_cond_tracker #(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               step_i,
    input  logic               first_i,
    input  logic               last_i,
    input  logic               sign_neg_i,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               carry_hi_i,
    input  logic               comp_add_i,
    input  logic               recomp_done_i,
    output logic [1:0]         cond_o,
    output logic               ovfl_o,
    output logic               recomp_req_o,
    output logic               done_o
);
    import dct_pkg::*;

    logic  digit_nz;
    logic  last_ok;
    logic  eq_after;
    logic  neg_after;
    cond_e cond_q;

    dct_digit_zero #(.DIGIT_W(DIGIT_W)) u_zero (
        .digit_i   (digit_i),
        .nonzero_o (digit_nz)
    );

    dct_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .step_i      (step_i),
        .first_i     (first_i),
        .last_i      (last_i),
        .sign_neg_i  (sign_neg_i),
        .digit_nz_i  (digit_nz),
        .last_ok_o   (last_ok),
        .eq_after_o  (eq_after),
        .neg_after_o (neg_after)
    );

    dct_cond_reg u_cond (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .last_ok_i     (last_ok),
        .eq_after_i    (eq_after),
        .neg_after_i   (neg_after),
        .comp_add_i    (comp_add_i),
        .carry_hi_i    (carry_hi_i),
        .recomp_done_i (recomp_done_i),
        .cond_o        (cond_q),
        .ovfl_o        (ovfl_o),
        .req_o         (recomp_req_o),
        .done_o        (done_o)
    );

    assign cond_o = cond_q;
endmodule

// File: rtl/dct_checker.sv
// Property checker for the condition tracker, attached through bind.
// Assumes only port-level visibility of the top module.
module dct_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       step_i,
    input logic       last_i,
    input logic       recomp_done_i,
    input logic [1:0] cond_o,
    input logic       ovfl_o,
    input logic       recomp_req_o,
    input logic       done_o
);
    assert_start_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cond_o == 2'b00 && !ovfl_o && !recomp_req_o));

    assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cond_o != 2'b11);

    assert_req_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recomp_req_o |-> cond_o == 2'b00);

    assert_req_rises_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recomp_req_o) |-> done_o);

    assert_ovfl_rises_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovfl_o) |-> done_o);

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(step_i && last_i));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_recomp_force_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (recomp_req_o && recomp_done_i && !start_i) |=> (cond_o == 2'b10 && !recomp_req_o));
endmodule

bind dec_cond_tracker dct_checker u_dct_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .step_i        (step_i),
    .last_i        (last_i),
    .recomp_done_i (recomp_done_i),
    .cond_o        (cond_o),
    .ovfl_o        (ovfl_o),
    .recomp_req_o  (recomp_req_o),
    .done_o        (done_o)
);

// File: tb/tb_dec_cond_tracker.sv
module tb_dec_cond_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 4;
    localparam int WATCHDOG_CYCLES = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          step_i = 1'b0;
    logic          first_i = 1'b0;
    logic          last_i = 1'b0;
    logic          sign_neg_i = 1'b0;
    logic [DW-1:0] digit_i = '0;
    logic          carry_hi_i = 1'b0;
    logic          comp_add_i = 1'b0;
    logic          recomp_done_i = 1'b0;
    logic [1:0]    cond_o;
    logic          ovfl_o;
    logic          recomp_req_o;
    logic          done_o;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    dec_cond_tracker #(.DIGIT_W(DW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .step_i        (step_i),
        .first_i       (first_i),
        .last_i        (last_i),
        .sign_neg_i    (sign_neg_i),
        .digit_i       (digit_i),
        .carry_hi_i    (carry_hi_i),
        .comp_add_i    (comp_add_i),
        .recomp_done_i (recomp_done_i),
        .cond_o        (cond_o),
        .ovfl_o        (ovfl_o),
        .recomp_req_o  (recomp_req_o),
        .done_o        (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stray step while no operation is open; outputs must not move (R9)
    task automatic stray_step();
        logic [1:0] c0;
        logic       o0;
        c0 = cond_o;
        o0 = ovfl_o;
        @(negedge clk);
        step_i = 1'b1; first_i = 1'b1; last_i = 1'b1; sign_neg_i = 1'b1;
        digit_i = 4'd7; comp_add_i = 1'b1; carry_hi_i = 1'b0;
        @(negedge clk);
        step_i = 1'b0; first_i = 1'b0; last_i = 1'b0; digit_i = '0;
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done", int'(done_o), 0);
        chk(cond_o == c0, "R9 cond", int'(cond_o), int'(c0));
        chk(ovfl_o == o0, "R9 ovfl", int'(ovfl_o), int'(o0));
    endtask

    task automatic run_op(input int len, input int mask, input bit neg,
                          input bit comp, input bit carry);
        bit         all_zero;
        logic [1:0] exp_cond;
        bit         exp_req;
        bit         exp_ovfl;
        all_zero = (mask == 0);
        exp_cond = all_zero ? 2'b00 : (neg ? 2'b01 : 2'b10);
        exp_req  = all_zero && neg;
        exp_ovfl = comp && !carry;

        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(cond_o == 2'b00, "R1 cond", int'(cond_o), 0);
        chk(ovfl_o == 1'b0, "R1 ovfl", int'(ovfl_o), 0);
        chk(recomp_req_o == 1'b0, "R1 req", int'(recomp_req_o), 0);

        for (int i = 0; i < len; i++) begin
            step_i     = 1'b1;
            first_i    = (i == 0);
            last_i     = (i == len - 1);
            sign_neg_i = (i == 0) ? neg : !neg;  // later signs must be ignored (R2)
            digit_i    = mask[i] ? DW'(i + 1) : '0;
            comp_add_i = comp;
            carry_hi_i = carry;
            @(negedge clk);
        end
        step_i = 1'b0; first_i = 1'b0; last_i = 1'b0; digit_i = '0;

        chk(done_o == 1'b1, "R7 done pulse", int'(done_o), 1);
        if (all_zero)
            chk(cond_o == exp_cond, neg ? "R5 cond" : "R4 cond", int'(cond_o), int'(exp_cond));
        else
            chk(cond_o == exp_cond, "R2/R3 cond", int'(cond_o), int'(exp_cond));
        chk(recomp_req_o == exp_req, exp_req ? "R5 req" : "R4 req", int'(recomp_req_o), int'(exp_req));
        chk(ovfl_o == exp_ovfl, "R6 ovfl", int'(ovfl_o), int'(exp_ovfl));

        @(negedge clk);
        chk(done_o == 1'b0, "R7 single cycle", int'(done_o), 0);

        recomp_done_i = 1'b1;
        @(negedge clk);
        recomp_done_i = 1'b0;
        if (exp_req) begin
            chk(cond_o == 2'b10, "R8 forced high", int'(cond_o), 2);
            chk(recomp_req_o == 1'b0, "R8 req cleared", int'(recomp_req_o), 0);
        end else begin
            chk(cond_o == exp_cond, "R8 no effect", int'(cond_o), int'(exp_cond));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cond_o == 2'b00, "R10 cond", int'(cond_o), 0);
        chk(ovfl_o == 1'b0, "R10 ovfl", int'(ovfl_o), 0);
        chk(recomp_req_o == 1'b0, "R10 req", int'(recomp_req_o), 0);
        chk(done_o == 1'b0, "R10 done", int'(done_o), 0);

        stray_step();
        for (int len = 1; len <= 3; len++)
            for (int mask = 0; mask < (1 << len); mask++)
                for (int s = 0; s < 2; s++)
                    for (int c = 0; c < 2; c++)
                        for (int k = 0; k < 2; k++) begin
                            run_op(len, mask, s[0], c[0], k[0]);
                            if (mask == 1 && s == 1) stray_step();
                        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule